// File: doc/BRIEF.md
# DDR4 Power-Up Initialization Sequencer

This block brings a DDR4 device from a cold, powered-down condition to the point where a training engine may take over. After a start request it waits for the supply to be reported stable. It then holds the memory reset low for a programmed number of cycles. Next it releases reset, starts the memory clock, and counts a second programmed interval before it raises clock enable. From there it writes the seven mode registers in a fixed order, one command at a time, and leaves a fixed gap after each one. It then issues a long ZQ calibration command, waits out the calibration interval, and raises a sticky done flag for the training engine.

The CAS latency code, the write-recovery code and the nominal termination code are static inputs. They are captured once, at the start request. The remaining mode-register bits come from a per-register base parameter. All wait lengths are parameters counted in controller clock cycles. Between commands the command bus always carries deselect. No phase can be skipped, repeated or reordered. Once the sequence has begun, only a reset brings the block back to idle.

Top module: `dram_init_seq`

## Requirements
- R1: While reset is asserted, memResetN, memClkEn, memCke and done are low and csN is high.
- R2: The block waits in idle until start, then waits for pwrStable. memResetN and memClkEn rise together exactly RST_CYC clock edges after the edge that first samples pwrStable high while the block is waiting for it. Without start, pwrStable alone changes nothing.
- R3: memCke rises exactly CKE_CYC cycles after memResetN rises.
- R4: Seven Mode Register Set commands are issued, selecting registers 3, 6, 5, 4, 2, 1, 0 in that order. The first comes MRD_CYC cycles after memCke rises, and each later one comes MRD_CYC cycles after the previous. An MRS is csN=0, actN=1, rasN=0, casN=0, weN=0. The register number is carried as {bg[0], ba[1], ba[0]}, and bg[1] is 0.
- R5: Each MRS address equals MR_BASE for that register, with these overlays. For register 0, cfgCasCode[3:1] goes to addr[6:4], cfgCasCode[0] goes to addr[2], and cfgWrCode goes to addr[11:9]. For register 1, cfgRttNom goes to addr[10:8].
- R6: The configuration inputs are sampled in the cycle start is accepted. Later changes to them do not alter any MRS address.
- R7: A ZQ long calibration (csN=0, actN=1, rasN=1, casN=1, weN=0, addr[10]=1) follows the last MRS by MRD_CYC cycles. done rises exactly ZQ_CYC cycles after it.
- R8: Every command lasts one cycle, and exactly eight commands are issued per sequence. In every other cycle csN is high.
- R9: done stays high until reset. A start request while the sequence runs, or after done, causes no restart and no further command.
- R10: Once risen, memResetN, memClkEn and memCke stay high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to begin the power-up sequence |
| pwrStable | input | 1 | Supply reported stable |
| cfgCasCode | input | 4 | CAS latency code for mode register 0 |
| cfgWrCode | input | 3 | Write-recovery code for mode register 0 |
| cfgRttNom | input | 3 | Nominal termination code for mode register 1 |
| memResetN | output | 1 | Device reset, active low |
| memClkEn | output | 1 | Enables the memory clock driver |
| memCke | output | 1 | Device clock enable |
| csN | output | 1 | Chip select, active low |
| actN | output | 1 | Activate command pin, active low |
| rasN | output | 1 | Row strobe / command bit |
| casN | output | 1 | Column strobe / command bit |
| weN | output | 1 | Write enable / command bit |
| ba | output | 2 | Bank address |
| bg | output | 2 | Bank group |
| addr | output | 17 | Address / mode-register payload |
| done | output | 1 | Sequence complete, sticky until reset |

## Verification
The assertions take MRD_CYC to be at least two, so that a command can be followed by deselect before the next one. They also take reset to be held for at least one edge at time zero, so the gap counter and the sticky flags start from a known state. The stimulus keeps the default gap of eight cycles. It asserts reset from the first edge, raises start and pwrStable only on falling clock edges, and holds every configuration input steady at the edge where start is accepted. It changes those inputs only after that edge, to show that they are ignored.

// File: rtl/dram_init_pkg.sv
package dram_init_pkg;
  localparam int ADDR_W = 17;
  localparam int NUM_MR = 7;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PWR, ST_RST, ST_CKE, ST_MRS, ST_ZQ, ST_DONE
  } seq_state_e;

  typedef enum logic [1:0] {LD_RST, LD_CKE, LD_MRD, LD_ZQ} load_sel_e;

  typedef struct packed {
    logic      capture;
    logic      load;
    load_sel_e loadSel;
    logic      runClk;
    logic      setCke;
    logic      issueMrs;
    logic      issueZq;
    logic      setDone;
  } seq_strobe_t;

  // Mode registers are written highest-dependency first; MR0 goes last.
  function automatic logic [2:0] mrOrder(input logic [2:0] idx);
    case (idx)
      3'd0:    return 3'd3;
      3'd1:    return 3'd6;
      3'd2:    return 3'd5;
      3'd3:    return 3'd4;
      3'd4:    return 3'd2;
      3'd5:    return 3'd1;
      default: return 3'd0;
    endcase
  endfunction
endpackage

// File: rtl/dram_init_ctrl.sv
module dram_init_ctrl
  import dram_init_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        pwrStable,
  input  logic        cntZero,
  input  logic        mrsLeft,
  output seq_strobe_t stb
);
  seq_state_e state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    stb       = '0;
    nextState = state;
    case (state)
      ST_IDLE: if (start) begin
        stb.capture = 1'b1;
        nextState   = ST_PWR;
      end
      ST_PWR: if (pwrStable) begin
        stb.load    = 1'b1;
        stb.loadSel = LD_RST;
        nextState   = ST_RST;
      end
      ST_RST: if (cntZero) begin
        stb.runClk  = 1'b1;
        stb.load    = 1'b1;
        stb.loadSel = LD_CKE;
        nextState   = ST_CKE;
      end
      ST_CKE: if (cntZero) begin
        stb.setCke  = 1'b1;
        stb.load    = 1'b1;
        stb.loadSel = LD_MRD;
        nextState   = ST_MRS;
      end
      ST_MRS: if (cntZero) begin
        stb.load = 1'b1;
        if (mrsLeft) begin
          stb.issueMrs = 1'b1;
          stb.loadSel  = LD_MRD;
        end else begin
          stb.issueZq = 1'b1;
          stb.loadSel = LD_ZQ;
          nextState   = ST_ZQ;
        end
      end
      ST_ZQ: if (cntZero) begin
        stb.setDone = 1'b1;
        nextState   = ST_DONE;
      end
      ST_DONE: nextState = ST_DONE;
      default: nextState = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/dram_init_dp.sv
module dram_init_dp
  import dram_init_pkg::*;
#(
  parameter int RST_CYC = 160000,
  parameter int CKE_CYC = 400000,
  parameter int MRD_CYC = 8,
  parameter int ZQ_CYC  = 1024,
  parameter logic [NUM_MR-1:0][ADDR_W-1:0] MR_BASE = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  seq_strobe_t       stb,
  input  logic [3:0]        cfgCasCode,
  input  logic [2:0]        cfgWrCode,
  input  logic [2:0]        cfgRttNom,
  output logic              cntZero,
  output logic              mrsLeft,
  output logic              memResetN,
  output logic              memClkEn,
  output logic              memCke,
  output logic              csN,
  output logic              actN,
  output logic              rasN,
  output logic              casN,
  output logic              weN,
  output logic [1:0]        ba,
  output logic [1:0]        bg,
  output logic [ADDR_W-1:0] addr,
  output logic              done
);
  localparam int MAX_AB = (RST_CYC > CKE_CYC) ? RST_CYC : CKE_CYC;
  localparam int MAX_CD = (MRD_CYC > ZQ_CYC) ? MRD_CYC : ZQ_CYC;
  localparam int MAX_C  = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
  localparam int CNT_W  = $clog2(MAX_C + 1);

  logic [CNT_W-1:0]  cnt, loadVal;
  logic [2:0]        mrIdx, mrSel;
  logic [3:0]        casQ;
  logic [2:0]        wrQ, rttQ;
  logic [ADDR_W-1:0] mrWord;

  assign cntZero = (cnt == '0);
  assign mrsLeft = (mrIdx != 3'(NUM_MR));
  assign mrSel   = mrOrder(mrIdx);

  always_comb begin
    case (stb.loadSel)
      LD_RST:  loadVal = CNT_W'(RST_CYC - 1);
      LD_CKE:  loadVal = CNT_W'(CKE_CYC - 1);
      LD_MRD:  loadVal = CNT_W'(MRD_CYC - 1);
      default: loadVal = CNT_W'(ZQ_CYC - 1);
    endcase
  end

  always_comb begin
    mrWord = MR_BASE[mrSel];
    if (mrSel == 3'd0) begin
      mrWord[6:4]  = casQ[3:1];
      mrWord[2]    = casQ[0];
      mrWord[11:9] = wrQ;
    end else if (mrSel == 3'd1) begin
      mrWord[10:8] = rttQ;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (stb.load) begin
      cnt <= loadVal;
    end else if (!cntZero) begin
      cnt <= cnt - CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      casQ <= '0;
      wrQ  <= '0;
      rttQ <= '0;
    end else if (stb.capture) begin
      casQ <= cfgCasCode;
      wrQ  <= cfgWrCode;
      rttQ <= cfgRttNom;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      memResetN <= 1'b0;
      memClkEn  <= 1'b0;
      memCke    <= 1'b0;
      done      <= 1'b0;
    end else begin
      if (stb.runClk) begin
        memResetN <= 1'b1;
        memClkEn  <= 1'b1;
      end
      if (stb.setCke)  memCke <= 1'b1;
      if (stb.setDone) done   <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mrIdx <= '0;
      csN   <= 1'b1;
      actN  <= 1'b1;
      rasN  <= 1'b1;
      casN  <= 1'b1;
      weN   <= 1'b1;
      ba    <= '0;
      bg    <= '0;
      addr  <= '0;
    end else begin
      csN  <= 1'b1;
      actN <= 1'b1;
      rasN <= 1'b1;
      casN <= 1'b1;
      weN  <= 1'b1;
      ba   <= '0;
      bg   <= '0;
      addr <= '0;
      if (stb.issueMrs) begin
        csN   <= 1'b0;
        rasN  <= 1'b0;
        casN  <= 1'b0;
        weN   <= 1'b0;
        ba    <= mrSel[1:0];
        bg    <= {1'b0, mrSel[2]};
        addr  <= mrWord;
        mrIdx <= mrIdx + 3'd1;
      end else if (stb.issueZq) begin
        csN      <= 1'b0;
        weN      <= 1'b0;
        addr[10] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/dram_init_seq.sv
module dram_init_seq
  import dram_init_pkg::*;
#(
  parameter int RST_CYC = 160000,
  parameter int CKE_CYC = 400000,
  parameter int MRD_CYC = 8,
  parameter int ZQ_CYC  = 1024,
  parameter logic [NUM_MR-1:0][ADDR_W-1:0] MR_BASE = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              pwrStable,
  input  logic [3:0]        cfgCasCode,
  input  logic [2:0]        cfgWrCode,
  input  logic [2:0]        cfgRttNom,
  output logic              memResetN,
  output logic              memClkEn,
  output logic              memCke,
  output logic              csN,
  output logic              actN,
  output logic              rasN,
  output logic              casN,
  output logic              weN,
  output logic [1:0]        ba,
  output logic [1:0]        bg,
  output logic [ADDR_W-1:0] addr,
  output logic              done
);
  seq_strobe_t stb;
  logic        cntZero, mrsLeft;

  dram_init_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .pwrStable(pwrStable),
    .cntZero(cntZero), .mrsLeft(mrsLeft), .stb(stb)
  );

  dram_init_dp #(
    .RST_CYC(RST_CYC), .CKE_CYC(CKE_CYC), .MRD_CYC(MRD_CYC),
    .ZQ_CYC(ZQ_CYC), .MR_BASE(MR_BASE)
  ) uDp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .cfgCasCode(cfgCasCode), .cfgWrCode(cfgWrCode), .cfgRttNom(cfgRttNom),
    .cntZero(cntZero), .mrsLeft(mrsLeft),
    .memResetN(memResetN), .memClkEn(memClkEn), .memCke(memCke),
    .csN(csN), .actN(actN), .rasN(rasN), .casN(casN), .weN(weN),
    .ba(ba), .bg(bg), .addr(addr), .done(done)
  );
endmodule

// File: rtl/dram_init_chk.sv
module dram_init_chk #(
  parameter int MRD_CYC = 8
) (
  input logic clk,
  input logic rstN,
  input logic memResetN,
  input logic memClkEn,
  input logic memCke,
  input logic csN,
  input logic actN,
  input logic rasN,
  input logic casN,
  input logic weN,
  input logic zqLong,
  input logic done
);
  localparam int GAP_W = $clog2(MRD_CYC + 1) + 1;

  logic [GAP_W-1:0] gap;
  logic             seenCmd;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      gap     <= '0;
      seenCmd <= 1'b0;
    end else if (!csN) begin
      gap     <= GAP_W'(1);
      seenCmd <= 1'b1;
    end else if (gap < GAP_W'(MRD_CYC)) begin
      gap <= gap + GAP_W'(1);
    end
  end

  AST_CLK_WITH_RESET: assert property (@(posedge clk) disable iff (!rstN)
    memClkEn == memResetN); // R2
  AST_CKE_NEEDS_CLK: assert property (@(posedge clk) disable iff (!rstN)
    memCke |-> (memClkEn && memResetN)); // R3
  AST_CMD_NEEDS_CKE: assert property (@(posedge clk) disable iff (!rstN)
    !csN |-> memCke); // R4
  AST_CMD_SPACING: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && seenCmd) |-> (gap >= GAP_W'(MRD_CYC))); // R4
  AST_CMD_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    !csN |-> (actN && !weN && ((!rasN && !casN) || (rasN && casN && zqLong)))); // R7
  AST_CMD_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    !csN |=> csN); // R8
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    done |=> done); // R9
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    done |-> csN); // R9
  AST_CKE_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    memCke |=> memCke); // R10
  AST_RESET_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    memResetN |=> memResetN); // R10
endmodule

bind dram_init_seq dram_init_chk #(.MRD_CYC(MRD_CYC)) uChk (
  .clk(clk), .rstN(rstN), .memResetN(memResetN), .memClkEn(memClkEn),
  .memCke(memCke), .csN(csN), .actN(actN), .rasN(rasN), .casN(casN),
  .weN(weN), .zqLong(addr[10]), .done(done)
);

// File: tb/sim_dram_init_seq.sv
`timescale 1ns/1ps
module sim_dram_init_seq;
  localparam int RST = 20;
  localparam int CKE = 30;
  localparam int MRD = 8;
  localparam int ZQ  = 64;
  localparam logic [6:0][16:0] TB_BASE = {17'h1C003, 17'h08421, 17'h10810,
                                          17'h00F0F, 17'h15555, 17'h0AAAA, 17'h1F0F1};
  localparam int ORDER [7] = '{3, 6, 5, 4, 2, 1, 0};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic pwrStable = 1'b0;
  logic [3:0] cfgCasCode = '0;
  logic [2:0] cfgWrCode = '0;
  logic [2:0] cfgRttNom = '0;
  logic memResetN, memClkEn, memCke, csN, actN, rasN, casN, weN, done;
  logic [1:0] ba, bg;
  logic [16:0] addr;

  always #10 clk = ~clk;

  dram_init_seq #(.RST_CYC(RST), .CKE_CYC(CKE), .MRD_CYC(MRD), .ZQ_CYC(ZQ),
                  .MR_BASE(TB_BASE)) u0 (
    .clk(clk), .rstN(rstN), .start(start), .pwrStable(pwrStable),
    .cfgCasCode(cfgCasCode), .cfgWrCode(cfgWrCode), .cfgRttNom(cfgRttNom),
    .memResetN(memResetN), .memClkEn(memClkEn), .memCke(memCke),
    .csN(csN), .actN(actN), .rasN(rasN), .casN(casN), .weN(weN),
    .ba(ba), .bg(bg), .addr(addr), .done(done)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 0;

  // event recorder
  int resetT, clkT, ckeT, doneT, nCmd, fallSeen, doneFell;
  int cmdT [16];
  int cmdKind [16];   // 1 = MRS, 2 = ZQ long, 0 = other
  int cmdMr [16];
  logic [16:0] cmdAddr [16];
  logic prevCke, prevRst, prevDone;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (!rstN) begin
      resetT = -1; clkT = -1; ckeT = -1; doneT = -1; nCmd = 0;
      fallSeen = 0; doneFell = 0;
      prevCke = 0; prevRst = 0; prevDone = 0;
    end else begin
      if (memResetN && resetT < 0) resetT = cyc;
      if (memClkEn && clkT < 0) clkT = cyc;
      if (memCke && ckeT < 0) ckeT = cyc;
      if (done && doneT < 0) doneT = cyc;
      if ((prevCke && !memCke) || (prevRst && !memResetN)) fallSeen = 1;
      if (prevDone && !done) doneFell = 1;
      prevCke = memCke; prevRst = memResetN; prevDone = done;
      if (!csN) begin
        if (nCmd < 16) begin
          cmdT[nCmd] = cyc;
          cmdAddr[nCmd] = addr;
          cmdMr[nCmd] = {bg[1], bg[0], ba};
          if (actN && !rasN && !casN && !weN) cmdKind[nCmd] = 1;
          else if (actN && rasN && casN && !weN && addr[10]) cmdKind[nCmd] = 2;
          else cmdKind[nCmd] = 0;
        end
        nCmd++;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [16:0] expAddr(input int mr, input logic [3:0] cas,
                                          input logic [2:0] wr, input logic [2:0] rtt);
    logic [16:0] w;
    w = TB_BASE[mr];
    if (mr == 0) begin
      w[6:4] = cas[3:1];
      w[2] = cas[0];
      w[11:9] = wr;
    end else if (mr == 1) begin
      w[10:8] = rtt;
    end
    return w;
  endfunction

  task automatic doReset();
    @(negedge clk);
    rstN = 0; start = 0; pwrStable = 0;
    repeat (3) @(negedge clk);
    chk(memResetN == 0 && memClkEn == 0, "R1 reset/clock low", {memResetN, memClkEn}, 0);
    chk(memCke == 0 && done == 0, "R1 cke/done low", {memCke, done}, 0);
    chk(csN == 1, "R1 deselect", csN, 1);
    rstN = 1;
  endtask

  task automatic runSeq(input logic [3:0] cas, input logic [2:0] wr,
                        input logic [2:0] rtt, input int pwrDelay);
    int pwrT, guard;
    doReset();
    cfgCasCode = cas; cfgWrCode = wr; cfgRttNom = rtt;
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    cfgCasCode = ~cas; cfgWrCode = ~wr; cfgRttNom = ~rtt;   // R6 late change
    repeat (pwrDelay) @(negedge clk);
    pwrStable = 1;
    pwrT = cyc;
    repeat (5) @(negedge clk);
    start = 1;                                             // R9 busy start
    @(negedge clk) start = 0;
    guard = 0;
    while (!done && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    repeat (3) @(negedge clk);
    chk(resetT - pwrT == RST + 1, "R2 reset release timing", resetT - pwrT, RST + 1);
    chk(clkT == resetT, "R2 clock starts with reset release", clkT, resetT);
    chk(ckeT - resetT == CKE, "R3 cke timing", ckeT - resetT, CKE);
    chk(nCmd == 8, "R8 command count", nCmd, 8);
    if (nCmd == 8) begin
      for (int i = 0; i < 7; i++) begin
        chk(cmdKind[i] == 1, "R4 MRS encoding", cmdKind[i], 1);
        chk(cmdMr[i] == ORDER[i], "R4 MRS order", cmdMr[i], ORDER[i]);
        chk(cmdT[i] == ckeT + MRD * (i + 1), "R4 MRS timing", cmdT[i], ckeT + MRD * (i + 1));
        chk(cmdAddr[i] == expAddr(ORDER[i], cas, wr, rtt), "R5 R6 MRS payload",
            cmdAddr[i], expAddr(ORDER[i], cas, wr, rtt));
      end
      chk(cmdKind[7] == 2, "R7 ZQ long encoding", cmdKind[7], 2);
      chk(cmdT[7] == ckeT + 8 * MRD, "R7 ZQ timing", cmdT[7], ckeT + 8 * MRD);
      chk(doneT - cmdT[7] == ZQ, "R7 done after ZQ wait", doneT - cmdT[7], ZQ);
    end
    chk(fallSeen == 0, "R10 no fall of reset or cke", fallSeen, 0);
  endtask

  task automatic idleHold();
    doReset();
    pwrStable = 1;
    repeat (RST + CKE + 20) @(negedge clk);
    chk(memResetN == 0 && memClkEn == 0, "R2 no start no release", {memResetN, memClkEn}, 0);
    chk(nCmd == 0, "R2 no command without start", nCmd, 0);
  endtask

  task automatic startAfterDone();
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    repeat (RST + CKE + 10 * MRD + ZQ) @(negedge clk);
    chk(nCmd == 8, "R9 no restart after done", nCmd, 8);
    chk(done == 1 && doneFell == 0, "R9 done sticky", done, 1);
  endtask

  initial begin
    idleHold();
    runSeq(4'b1011, 3'b101, 3'b011, 3);
    startAfterDone();
    runSeq(4'b0110, 3'b010, 3'b100, 9);
    runSeq(4'b1111, 3'b111, 3'b111, 1);
    doReset();
    chk(done == 0 && memCke == 0, "R1 reset clears done", {done, memCke}, 0);
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule